// File: doc/BRIEF.md
# Endian-Aware Load/Store Byte Lane Unit

This block sits between a core's load/store path and a 32-bit wide data memory. For stores it places the write data on the byte lanes of the memory word and raises the byte enables of exactly the lanes being written. For loads it picks the addressed byte or halfword out of the fetched word and widens it to 32 bits with zero or sign extension. A whole-word load at an address that is not word aligned is handled by fetching the aligned word and rotating it, which avoids an alignment fault. The aligned memory address is driven alongside the enables.

Byte order is held in a two-state machine. The state register resets to ORDER_LITTLE. A cycle with the order-write strobe high and a big-endian request moves it from ORDER_LITTLE to ORDER_BIG. A cycle with the strobe high and a little-endian request moves it from ORDER_BIG back to ORDER_LITTLE. The new order applies from the clock edge that samples the strobe. With the strobe low, each state holds. Only the lane selection for byte and halfword accesses and the direction of the unaligned rotation depend on the order; whole-word lane usage does not change. Everything else is combinational from the inputs and the current order.

The size code is 00 for byte, 01 for halfword and 10 for word; 11 is treated as word.

Top module: `lsu_byte_lane`

## Requirements
- R1: A byte access enables exactly one lane: lane a (a = address bits 1:0) when the order is little-endian, lane 3-a when it is big-endian. be_o bit n is lane n, carried by data bits 8n+7:8n.
- R2: A halfword access enables lanes 1:0 (be_o = 0011) when address bit 1 is 0 and lanes 3:2 (1100) when it is 1, in little-endian order. Big-endian order swaps the two patterns.
- R3: A word access enables all four lanes (be_o = 1111) and passes the store data through unchanged, in either order.
- R4: For a byte store, wdata_o carries the low 8 bits of the store data on all four lanes. For a halfword store, it carries the low 16 bits on both halves.
- R5: maddr_o equals the address for byte accesses, the address with bit 0 cleared for halfwords, and the address with bits 1:0 cleared for words.
- R6: A byte load returns the byte from the lane chosen as in R1, zero-extended when signed_i is 0 and sign-extended from its bit 7 when signed_i is 1.
- R7: A halfword load returns the half chosen as in R2 (bits 15:0 or 31:16), zero- or sign-extended from its bit 15 according to signed_i.
- R8: With rotation enabled and little-endian order, a word load returns the fetched word rotated right by 8 times address bits 1:0.
- R9: With rotation enabled and big-endian order, a word load returns the fetched word rotated left by 8 times address bits 1:0.
- R10: With rotation disabled, a word load returns the fetched word unchanged, whatever the address bits 1:0 and the order.
- R11: The order is little-endian after reset. It changes only on a clock edge where ord_wr_i is high, and then to the value of ord_big_i (1 = big-endian). ord_big_i has no effect while ord_wr_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, returns order to little-endian |
| ord_wr_i | input | 1 | Order-write strobe |
| ord_big_i | input | 1 | Requested order on a write: 1 big-endian, 0 little-endian |
| rot_en_i | input | 1 | Rotate unaligned word loads when 1 |
| addr_i | input | 32 | Byte address of the access |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| signed_i | input | 1 | Sign-extend byte and halfword loads |
| wdata_i | input | 32 | Store data, right-justified |
| rdata_i | input | 32 | Word read from memory |
| be_o | output | 4 | Byte enables, bit n for lane n |
| maddr_o | output | 32 | Aligned memory address |
| wdata_o | output | 32 | Store data steered onto the lanes |
| rdata_o | output | 32 | Extended or rotated load result |

## Verification
The hardest case to reach is a lane mapping in the big-endian state. It exists only after a registered order write, and a strobe-low cycle with the request raised must not reach it. The stimulus makes each order change with a single strobed cycle at the falling edge. It then sweeps all four address offsets over every size and both sign settings. It also holds the request high with the strobe low over several edges, and confirms through the byte enables that the order has stayed little-endian. The test read word mixes set and clear top bits in different lanes, so the sign extension and the direction of the rotation each give a distinct value.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WRSV = 2'b11
    } acc_size_e;

    typedef enum logic {
        ORDER_LITTLE = 1'b0,
        ORDER_BIG    = 1'b1
    } byte_order_e;

endpackage

// File: rtl/lane_order_fsm.sv
module lane_order_fsm
    import lsu_lane_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ord_wr_i,
    input  logic ord_big_i,
    output logic big_o
);

    byte_order_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ORDER_LITTLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ORDER_LITTLE: if (ord_wr_i && ord_big_i)  state_d = ORDER_BIG;
            ORDER_BIG:    if (ord_wr_i && !ord_big_i) state_d = ORDER_LITTLE;
            default:      state_d = ORDER_LITTLE;
        endcase
    end

    always_comb begin
        big_o = (state_q == ORDER_BIG);
    end

    // R11: order holds without a write strobe
    a_r11_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ord_wr_i |=> $stable(big_o));

    // R11: a strobed write lands the requested order
    a_r11_write_takes_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ord_wr_i |=> (big_o == $past(ord_big_i)));

endmodule

// File: rtl/lane_map.sv
module lane_map
    import lsu_lane_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned NLANES = DATA_W / 8,
    localparam int unsigned NHALF  = NLANES / 2,
    localparam int unsigned OFS_W  = $clog2(NLANES),
    localparam int unsigned HID_W  = OFS_W - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  acc_size_e         size_i,
    input  logic              big_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NLANES-1:0] be_o,
    output logic [ADDR_W-1:0] maddr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [OFS_W-1:0]  lane_o,
    output logic [HID_W-1:0]  half_o
);

    logic [OFS_W-1:0] ofs;

    assign ofs    = addr_i[OFS_W-1:0];
    assign lane_o = big_i ? OFS_W'(NLANES - 1) - ofs : ofs;
    assign half_o = big_i ? HID_W'(NHALF - 1) - ofs[OFS_W-1:1] : ofs[OFS_W-1:1];

    for (genvar i = 0; i < NLANES; i++) begin : g_lane_en
        localparam int unsigned HI = i / 2;
        always_comb begin
            unique case (size_i)
                SZ_BYTE: be_o[i] = (lane_o == OFS_W'(i));
                SZ_HALF: be_o[i] = (half_o == HID_W'(HI));
                default: be_o[i] = 1'b1;
            endcase
        end
    end

    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin
                maddr_o = addr_i;
                wdata_o = {NLANES{wdata_i[7:0]}};
            end
            SZ_HALF: begin
                maddr_o = {addr_i[ADDR_W-1:1], 1'b0};
                wdata_o = {NHALF{wdata_i[15:0]}};
            end
            default: begin
                maddr_o = {addr_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
                wdata_o = wdata_i;
            end
        endcase
    end

    // R1: one lane for a byte
    a_r1_byte_single_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (size_i == SZ_BYTE) |-> ($countones(be_o) == 1));

    // R2: two lanes for a halfword
    a_r2_half_two_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (size_i == SZ_HALF) |-> ($countones(be_o) == 2 && be_o[0] == be_o[1]));

    // R3: all lanes for a word
    a_r3_word_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (size_i == SZ_WORD) |-> (&be_o && wdata_o == wdata_i));

    // R5: word address aligned
    a_r5_word_addr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (size_i == SZ_WORD) |-> (maddr_o[OFS_W-1:0] == '0));

endmodule

// File: rtl/load_align.sv
module load_align
    import lsu_lane_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned NLANES = DATA_W / 8,
    localparam int unsigned NHALF  = NLANES / 2,
    localparam int unsigned OFS_W  = $clog2(NLANES),
    localparam int unsigned HID_W  = OFS_W - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] rdata_i,
    input  acc_size_e         size_i,
    input  logic              signed_i,
    input  logic              rot_en_i,
    input  logic              big_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [OFS_W-1:0]  lane_i,
    input  logic [HID_W-1:0]  half_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [7:0]          lane_b [NLANES];
    logic [15:0]         half_h [NHALF];
    logic [2*DATA_W-1:0] dbl;
    logic [OFS_W-1:0]    rot_amt;
    logic [DATA_W-1:0]   rot_w;
    logic [7:0]          sel_b;
    logic [15:0]         sel_h;

    for (genvar i = 0; i < NLANES; i++) begin : g_bytes
        assign lane_b[i] = rdata_i[8*i +: 8];
    end

    for (genvar j = 0; j < NHALF; j++) begin : g_halves
        assign half_h[j] = rdata_i[16*j +: 16];
    end

    assign sel_b   = lane_b[lane_i];
    assign sel_h   = half_h[half_i];
    assign dbl     = {rdata_i, rdata_i};
    assign rot_amt = big_i ? (OFS_W'(0) - ofs_i) : ofs_i;
    assign rot_w   = dbl[{rot_amt, 3'b000} +: DATA_W];

    always_comb begin
        unique case (size_i)
            SZ_BYTE: rdata_o = {{(DATA_W-8){signed_i & sel_b[7]}}, sel_b};
            SZ_HALF: rdata_o = {{(DATA_W-16){signed_i & sel_h[15]}}, sel_h};
            default: rdata_o = rot_en_i ? rot_w : rdata_i;
        endcase
    end

    // R6: unsigned byte load has a clear upper part
    a_r6_byte_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (size_i == SZ_BYTE && !signed_i) |-> (rdata_o[DATA_W-1:8] == '0));

    // R7: unsigned halfword load has a clear upper part
    a_r7_half_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (size_i == SZ_HALF && !signed_i) |-> (rdata_o[DATA_W-1:16] == '0));

    // R10: no rotation passes the word through
    a_r10_word_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (size_i == SZ_WORD && !rot_en_i) |-> (rdata_o == rdata_i));

endmodule

// File: rtl/lsu_byte_lane.sv
module lsu_byte_lane
    import lsu_lane_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned NLANES = DATA_W / 8,
    localparam int unsigned OFS_W  = $clog2(NLANES),
    localparam int unsigned HID_W  = OFS_W - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ord_wr_i,
    input  logic              ord_big_i,
    input  logic              rot_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              signed_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [NLANES-1:0] be_o,
    output logic [ADDR_W-1:0] maddr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o
);

    acc_size_e        sz;
    logic             big;
    logic [OFS_W-1:0] lane;
    logic [HID_W-1:0] half;

    assign sz = acc_size_e'(size_i);

    lane_order_fsm u_order (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ord_wr_i  (ord_wr_i),
        .ord_big_i (ord_big_i),
        .big_o     (big)
    );

    lane_map #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_map (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .addr_i  (addr_i),
        .size_i  (sz),
        .big_i   (big),
        .wdata_i (wdata_i),
        .be_o    (be_o),
        .maddr_o (maddr_o),
        .wdata_o (wdata_o),
        .lane_o  (lane),
        .half_o  (half)
    );

    load_align #(.DATA_W(DATA_W)) u_load (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rdata_i  (rdata_i),
        .size_i   (sz),
        .signed_i (signed_i),
        .rot_en_i (rot_en_i),
        .big_i    (big),
        .ofs_i    (addr_i[OFS_W-1:0]),
        .lane_i   (lane),
        .half_i   (half),
        .rdata_o  (rdata_o)
    );

endmodule

// File: tb/lsu_byte_lane_tb.sv
module lsu_byte_lane_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ord_wr = 1'b0;
    logic        ord_big = 1'b0;
    logic        rot_en = 1'b1;
    logic [31:0] addr = '0;
    logic [1:0]  size = 2'b00;
    logic        sgn = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata = '0;
    logic [3:0]  be;
    logic [31:0] maddr, wdata_q, rdata_q;

    int checks = 0;
    int fails  = 0;

    localparam logic [31:0] BASE  = 32'h0000_4A30;
    localparam logic [31:0] RWORD = 32'h8A7F_3C91;
    localparam logic [31:0] SWORD = 32'h1234_56A5;

    always #2 clk = ~clk;

    lsu_byte_lane dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .ord_wr_i  (ord_wr),
        .ord_big_i (ord_big),
        .rot_en_i  (rot_en),
        .addr_i    (addr),
        .size_i    (size),
        .signed_i  (sgn),
        .wdata_i   (wdata),
        .rdata_i   (rdata),
        .be_o      (be),
        .maddr_o   (maddr),
        .wdata_o   (wdata_q),
        .rdata_o   (rdata_q)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [1:0] s, input logic sg);
        @(negedge clk);
        addr = a; size = s; sgn = sg;
        #1;
    endtask

    task automatic set_order(input logic big);
        @(negedge clk);
        ord_wr = 1'b1; ord_big = big;
        @(posedge clk);
        #1;
        ord_wr = 1'b0;
    endtask

    task automatic t_reset_state;
        rdata = RWORD;
        apply(BASE, 2'b00, 1'b0);
        chk("R11 reset order little (be)", {28'd0, be}, 32'h1);
        chk("R11 reset order little (load)", rdata_q, 32'h91);
    endtask

    task automatic t_order_hold;
        @(negedge clk);
        ord_wr = 1'b0; ord_big = 1'b1;
        repeat (3) @(posedge clk);
        apply(BASE + 1, 2'b00, 1'b0);
        chk("R11 request without strobe ignored", {28'd0, be}, 32'h2);
        ord_big = 1'b0;
    endtask

    task automatic t_byte_store(input logic big);
        wdata = SWORD;
        for (int a = 0; a < 4; a++) begin
            apply(BASE + a, 2'b00, 1'b0);
            chk("R1 byte enable", {28'd0, be}, big ? (32'h8 >> a) : (32'h1 << a));
            chk("R4 byte replicate", wdata_q, 32'hA5A5_A5A5);
            chk("R5 byte address", maddr, BASE + a);
        end
    endtask

    task automatic t_half_store(input logic big);
        wdata = SWORD;
        for (int a = 0; a < 4; a++) begin
            logic upper;
            upper = (a >= 2) ^ big;
            apply(BASE + a, 2'b01, 1'b0);
            chk("R2 half enable", {28'd0, be}, upper ? 32'hC : 32'h3);
            chk("R4 half replicate", wdata_q, 32'h56A5_56A5);
            chk("R5 half address", maddr, (BASE + a) & 32'hFFFF_FFFE);
        end
    endtask

    task automatic t_word_store(input logic big);
        wdata = SWORD;
        for (int a = 0; a < 4; a++) begin
            apply(BASE + a, (a == 3) ? 2'b11 : 2'b10, 1'b0);
            chk(big ? "R3 word enable big" : "R3 word enable little", {28'd0, be}, 32'hF);
            chk("R3 word data unchanged", wdata_q, SWORD);
            chk("R5 word address", maddr, (BASE + a) & 32'hFFFF_FFFC);
        end
    endtask

    task automatic t_byte_load(input logic big);
        rdata = RWORD;
        for (int a = 0; a < 4; a++) begin
            for (int s = 0; s < 2; s++) begin
                int lane;
                logic [7:0] b;
                logic [31:0] e;
                lane = big ? 3 - a : a;
                b = RWORD[8*lane +: 8];
                e = (s == 1 && b[7]) ? {24'hFF_FFFF, b} : {24'd0, b};
                apply(BASE + a, 2'b00, s[0]);
                chk("R6 byte load", rdata_q, e);
            end
        end
    endtask

    task automatic t_half_load(input logic big);
        rdata = RWORD;
        for (int a = 0; a < 4; a += 2) begin
            for (int s = 0; s < 2; s++) begin
                int hi;
                logic [15:0] h;
                logic [31:0] e;
                hi = ((a >= 2) ? 1 : 0) ^ (big ? 1 : 0);
                h = RWORD[16*hi +: 16];
                e = (s == 1 && h[15]) ? {16'hFFFF, h} : {16'd0, h};
                apply(BASE + a, 2'b01, s[0]);
                chk("R7 half load", rdata_q, e);
            end
        end
    endtask

    task automatic t_rot_word(input logic big);
        rdata = RWORD;
        rot_en = 1'b1;
        for (int a = 0; a < 4; a++) begin
            logic [31:0] e;
            if (a == 0) e = RWORD;
            else if (!big) e = (RWORD >> (8*a)) | (RWORD << (32 - 8*a));
            else e = (RWORD << (8*a)) | (RWORD >> (32 - 8*a));
            apply(BASE + a, 2'b10, 1'b0);
            chk(big ? "R9 rotate left big-endian" : "R8 rotate right little-endian", rdata_q, e);
        end
    endtask

    task automatic t_no_rot(input logic big);
        rdata = RWORD;
        rot_en = 1'b0;
        for (int a = 0; a < 4; a++) begin
            apply(BASE + a, 2'b10, 1'b1);
            chk(big ? "R10 raw word big" : "R10 raw word little", rdata_q, RWORD);
        end
        rot_en = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_order_hold();
        t_byte_store(1'b0);
        t_half_store(1'b0);
        t_word_store(1'b0);
        t_byte_load(1'b0);
        t_half_load(1'b0);
        t_rot_word(1'b0);
        t_no_rot(1'b0);
        set_order(1'b1);
        t_byte_store(1'b1);
        t_half_store(1'b1);
        t_word_store(1'b1);
        t_byte_load(1'b1);
        t_half_load(1'b1);
        t_rot_word(1'b1);
        t_no_rot(1'b1);
        set_order(1'b0);
        apply(BASE + 3, 2'b00, 1'b0);
        chk("R11 return to little", {28'd0, be}, 32'h8);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule